// File: doc/BRIEF.md
# Level-Testable Generate/Propagate Reduction Tree

This block folds 2^LEVELS bit-level carry-lookahead pairs, each made of a generate bit and a propagate bit, into a single group pair through a balanced binary tree of combine cells. Level 1 is the single root cell, and level LEVELS is the row of cells that reads the input pairs directly. The root result is registered, so it appears one clock after the inputs are presented.

Every level has its own test-mode bit. With its bit clear, a level performs the ordinary lookahead combine. With its bit set, every cell of that level outputs the bitwise XOR of its two inputs. In that mode a cell gives zero only when its two inputs agree, and it can still produce any 2-bit value.

To test one level, a controller drives the same input combination into every cell of that level and sets the test bits of all levels closer to the root. A fault-free tree then returns zero at the root. Any single cell whose result differs makes the root nonzero and raises a registered error flag. Sixteen combinations cover one level, so at most 16·LEVELS patterns cover the whole tree.

Top module: `gp_level_tree`

## Requirements
- R1: While `rstN` is low, `gpOut` is 2'b00 and `errFlag` is 0.
- R2: `gpOut` and `errFlag` show the result of the inputs sampled at the previous rising clock edge, and they hold steady between edges.
- R3: A pair is {G,P}, with G in the upper bit. Input pair k is `gpIn[2k+1:2k]`, and a higher k is more significant. With all test bits clear, the root is the lookahead combine of all pairs, where one cell gives G = Ghi | (Phi & Glo) and P = Phi & Plo.
- R4: With all test bits clear, the root P bit is the AND of every input P bit, and the root G bit is 0 when no input G bit is set.
- R5: `levelTest[l-1]` controls level l, which has 2^(l-1) cells. Cell j of level l combines pair 2j+1 (hi) with pair 2j (lo) of the level below. While that bit is 1, every cell of the level outputs hi XOR lo.
- R6: When the test bits of levels 1..l-1 are 1, level l and the levels below it are 0, and every level-l cell computes the same result, the root is 2'b00.
- R7: In the setup of R6, if exactly one level-l cell computes a different result, then the root is nonzero and `errFlag` is 1.
- R8: `errFlag` is 1 exactly when some `levelTest` bit was 1 and the root result was nonzero, both taken from the same sampled cycle.
- R9: With all test bits clear, `errFlag` stays 0 for any input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| gpIn | input | 2·2^LEVELS | Bit-level {G,P} pairs; pair k at bits 2k+1:2k |
| levelTest | input | LEVELS | Per-level identity-mode select; bit l-1 drives level l |
| gpOut | output | 2 | Registered root {G,P} |
| errFlag | output | 1 | Registered mismatch flag for level tests |

## Verification
With all test bits clear, the bench tries every one of the 65536 input vectors of a three-level tree. It compares each result with an arithmetic lookahead model, which shows whether the combine rule, the ordering of the pairs and the P-chain are right. It then tries every mixed test-bit setting over a strided set of vectors, which separates identity levels from normal levels and exposes any mix-up of bits between levels. For each level it runs all 16 per-cell combinations with agreeing cells, and then again with one cell made to disagree. The agreeing runs must give a zero root. The disagreeing runs must raise the flag.

// File: rtl/gpt_pkg.sv
package gpt_pkg;

  localparam int MAX_LEVELS = 6;

  typedef logic [1:0] gp_pair_t;

  typedef struct packed {
    logic [MAX_LEVELS-1:0] identMode;
    logic                  anyTest;
  } tree_ctl_t;

  function automatic gp_pair_t gpCombine(input gp_pair_t hiPair, input gp_pair_t loPair);
    gp_pair_t res;
    res[1] = hiPair[1] | (hiPair[0] & loPair[1]);
    res[0] = hiPair[0] & loPair[0];
    return res;
  endfunction

endpackage

// File: rtl/gpt_cell.sv
module gpt_cell
  import gpt_pkg::*;
(
  input  logic [1:0] hiIn,
  input  logic [1:0] loIn,
  input  logic       identSel,
  output logic [1:0] cellOut
);

  gp_pair_t normalRes;
  gp_pair_t identRes;

  always_comb begin
    normalRes = gpCombine(hiIn, loIn);
    identRes  = hiIn ^ loIn;
    cellOut   = identSel ? identRes : normalRes;
  end

endmodule

// File: rtl/gpt_ctrl.sv
module gpt_ctrl
  import gpt_pkg::*;
#(
  parameter int LEVELS = 3
) (
  input  logic [LEVELS-1:0] levelTest,
  output tree_ctl_t         strobes
);

  if (LEVELS < 2 || LEVELS > MAX_LEVELS) begin : gBadLevels
    $error("gpt_ctrl: LEVELS out of supported range");
  end

  always_comb begin
    strobes                         = '0;
    strobes.identMode[LEVELS-1:0]   = levelTest;
    strobes.anyTest                 = |levelTest;
  end

endmodule

// File: rtl/gpt_datapath.sv
module gpt_datapath
  import gpt_pkg::*;
#(
  parameter int LEVELS = 3,
  localparam int NLEAF = 1 << LEVELS,
  localparam int IN_W  = 2 * NLEAF
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [IN_W-1:0] gpIn,
  input  tree_ctl_t       strobes,
  output logic [1:0]      rootOut,
  output logic            errOut
);

  // Levels are built from the inputs upward so each level refers to one
  // already elaborated below it.
  for (genvar l = LEVELS; l >= 1; l--) begin : gLvl
    localparam int CELLS = 1 << (l - 1);
    logic [4*CELLS-1:0] inBus;
    logic [2*CELLS-1:0] outBus;

    if (l == LEVELS) begin : gLeaf
      assign inBus = gpIn;
    end else begin : gInner
      assign inBus = gLvl[l+1].outBus;
    end

    for (genvar j = 0; j < CELLS; j++) begin : gCell
      gpt_cell u_cell (
        .hiIn    (inBus[4*j+3 : 4*j+2]),
        .loIn    (inBus[4*j+1 : 4*j]),
        .identSel(strobes.identMode[l-1]),
        .cellOut (outBus[2*j+1 : 2*j])
      );
    end
  end

  logic [1:0] rootD;
  logic       errD;
  logic       unusedModeBits;

  assign rootD          = gLvl[1].outBus;
  assign errD           = strobes.anyTest && (rootD != 2'b00);
  assign unusedModeBits = ^strobes.identMode;

  logic [1:0] rootQ;
  logic       errQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rootQ <= 2'b00;
      errQ  <= 1'b0;
    end else begin
      rootQ <= rootD;
      errQ  <= errD;
    end
  end

  assign rootOut = rootQ;
  assign errOut  = errQ;

  // Leaf bit views used only by the checks below.
  logic [NLEAF-1:0] gBits;
  logic [NLEAF-1:0] pBits;
  for (genvar k = 0; k < NLEAF; k++) begin : gSplit
    assign gBits[k] = gpIn[2*k+1];
    assign pBits[k] = gpIn[2*k];
  end

  a_r4_prop_chain: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.anyTest |=> rootQ[0] == $past(&pBits));

  a_r4_no_generate: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.anyTest && !(|gBits)) |=> rootQ[1] == 1'b0);

  a_r9_quiet_flag: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.anyTest |=> !errQ);

  a_r8_flag_needs_root: assert property (@(posedge clk) disable iff (!rstN)
    errQ |-> rootQ != 2'b00);

  a_r5_root_ident_zero: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.identMode[0] && (gLvl[1].inBus[3:2] == gLvl[1].inBus[1:0])) |=> rootQ == 2'b00);

endmodule

// File: rtl/gp_level_tree.sv
module gp_level_tree
  import gpt_pkg::*;
#(
  parameter int LEVELS = 3,
  localparam int NLEAF = 1 << LEVELS,
  localparam int IN_W  = 2 * NLEAF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [IN_W-1:0]   gpIn,
  input  logic [LEVELS-1:0] levelTest,
  output logic [1:0]        gpOut,
  output logic              errFlag
);

  tree_ctl_t strobes;

  gpt_ctrl #(.LEVELS(LEVELS)) u_ctrl (
    .levelTest(levelTest),
    .strobes  (strobes)
  );

  gpt_datapath #(.LEVELS(LEVELS)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .gpIn   (gpIn),
    .strobes(strobes),
    .rootOut(gpOut),
    .errOut (errFlag)
  );

endmodule

// File: tb/gp_level_tree_bench.sv
module gp_level_tree_bench;

  localparam int LEVELS     = 3;
  localparam int NLEAF      = 1 << LEVELS;
  localparam int IN_W       = 2 * NLEAF;
  localparam int CLK_PERIOD = 10;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [IN_W-1:0]   gpIn = '0;
  logic [LEVELS-1:0] levelTest = '0;
  logic [1:0]        gpOut;
  logic              errFlag;

  int  checks = 0;
  int  failures = 0;
  bit  done = 1'b0;

  gp_level_tree #(.LEVELS(LEVELS)) u_gp_level_tree (
    .clk      (clk),
    .rstN     (rstN),
    .gpIn     (gpIn),
    .levelTest(levelTest),
    .gpOut    (gpOut),
    .errFlag  (errFlag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [1:0] cellRef(logic [1:0] hi, logic [1:0] lo, logic ident);
    if (ident) return hi ^ lo;
    return {hi[1] | (hi[0] & lo[1]), hi[0] & lo[0]};
  endfunction

  function automatic logic [1:0] treeRef(logic [IN_W-1:0] leaves, logic [LEVELS-1:0] ctl);
    logic [1:0] cur [NLEAF];
    int n;
    for (int k = 0; k < NLEAF; k++) cur[k] = leaves[2*k +: 2];
    n = NLEAF;
    for (int lvl = LEVELS; lvl >= 1; lvl--) begin
      for (int j = 0; j < n/2; j++) cur[j] = cellRef(cur[2*j+1], cur[2*j], ctl[lvl-1]);
      n = n / 2;
    end
    return cur[0];
  endfunction

  // Inputs that make every level-l cell see (hiVal, loVal); cell faultCell
  // sees faultHi instead of hiVal when faultCell is nonnegative.
  function automatic logic [IN_W-1:0] buildLevel(int l, logic [1:0] hiVal, logic [1:0] loVal,
                                                  int faultCell, logic [1:0] faultHi);
    logic [IN_W-1:0] v;
    int blk;
    int half;
    blk  = NLEAF >> (l - 1);
    half = blk / 2;
    for (int k = 0; k < NLEAF; k++) v[2*k +: 2] = 2'b01;
    for (int c = 0; c < (1 << (l - 1)); c++) begin
      v[2*(c*blk + half - 1) +: 2] = loVal;
      v[2*(c*blk + blk - 1) +: 2]  = (c == faultCell) ? faultHi : hiVal;
    end
    return v;
  endfunction

  task automatic check2(string tag, logic [1:0] act, logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic check1(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic apply(logic [IN_W-1:0] vec, logic [LEVELS-1:0] ctl);
    @(negedge clk);
    gpIn      = vec;
    levelTest = ctl;
    @(negedge clk);
  endtask

  initial begin
    logic [1:0] exp;
    // R1: reset state with busy inputs
    gpIn      = '1;
    levelTest = '1;
    repeat (3) @(negedge clk);
    check2("R1 gpOut in reset", gpOut, 2'b00);
    check1("R1 errFlag in reset", errFlag, 1'b0);
    rstN = 1'b1;

    // R2: one-cycle latency, outputs hold between edges
    apply('0, '0);
    check2("R2 settled zero", gpOut, 2'b00);
    @(negedge clk);
    gpIn = '1;
    #1;
    check2("R2 no change before edge", gpOut, 2'b00);
    @(negedge clk);
    check2("R2 update after edge", gpOut, 2'b11);

    // R3 / R4 / R9: exhaustive sweep in normal mode
    for (int v = 0; v < (1 << IN_W); v++) begin
      logic [IN_W-1:0] vec;
      logic andP;
      logic anyG;
      vec = IN_W'(v);
      apply(vec, '0);
      exp = treeRef(vec, '0);
      check2("R3 normal root", gpOut, exp);
      andP = 1'b1;
      anyG = 1'b0;
      for (int k = 0; k < NLEAF; k++) begin
        andP &= vec[2*k];
        anyG |= vec[2*k+1];
      end
      check1("R4 root P chain", gpOut[0], andP);
      if (!anyG) check1("R4 no generate", gpOut[1], 1'b0);
      check1("R9 flag quiet", errFlag, 1'b0);
    end

    // R5 / R8: every mixed test-bit setting over strided vectors
    for (int ctl = 1; ctl < (1 << LEVELS); ctl++) begin
      for (int i = 0; i < 2048; i++) begin
        logic [IN_W-1:0] vec;
        vec = IN_W'(i * 31 + ctl);
        apply(vec, LEVELS'(ctl));
        exp = treeRef(vec, LEVELS'(ctl));
        check2("R5 mixed-mode root", gpOut, exp);
        check1("R8 flag rule", errFlag, exp != 2'b00);
      end
    end

    // R6 / R7: level tests, agreeing cells then one disagreeing cell
    for (int l = 1; l <= LEVELS; l++) begin
      logic [LEVELS-1:0] ctl;
      ctl = LEVELS'((1 << (l - 1)) - 1);
      for (int combo = 0; combo < 16; combo++) begin
        logic [1:0] hiV;
        logic [1:0] loV;
        logic [1:0] badHi;
        hiV = combo[3:2];
        loV = combo[1:0];
        apply(buildLevel(l, hiV, loV, -1, 2'b00), ctl);
        if (l == 1) begin
          check2("R6 level1 root", gpOut, cellRef(hiV, loV, 1'b0));
          check1("R6 level1 flag", errFlag, 1'b0);
        end else begin
          check2("R6 agreeing level root", gpOut, 2'b00);
          check1("R6 agreeing level flag", errFlag, 1'b0);
          badHi = hiV;
          for (int a = 0; a < 4; a++)
            if (badHi == hiV && cellRef(2'(a), loV, 1'b0) != cellRef(hiV, loV, 1'b0)) badHi = 2'(a);
          apply(buildLevel(l, hiV, loV, (combo % (1 << (l - 1))), badHi), ctl);
          check1("R7 disagreeing cell flag", errFlag, 1'b1);
          checks++;
          if (gpOut == 2'b00) begin
            failures++;
            $display("FAIL R7 disagreeing cell root: actual=%b expected=nonzero", gpOut);
          end
        end
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule